// File: doc/BRIEF.md
# Masked Vector Execution Unit

This block executes one element-wise vector operation at a time over a small bank of vector registers. The operation is steered by a per-element mask register. Compare operations produce the mask. Arithmetic and copy operations read it, so only the selected destination elements change. A mask-complement command inverts the mask. Two masked copies separated by a complement therefore form an element-wise select, for example a maximum of two vectors.

Each run handles one element per clock. A mode pin picks the sequencing when the run starts. In the gated mode every element below the vector length is visited, and the mask only enables the write. In the density-time mode the unit scans the mask and visits only elements whose bit is set, so sparse masks finish sooner. A host port loads single elements, and a combinational read port shows any element. Control and status pins are plain level signals: `start` is taken only while `busy` is low, and `done` marks completion. The unit has no back-pressure. A run lasts a fixed number of cycles that can be known before it starts.

Top module: `vmx_unit`

## Requirements
- R1: After reset, `busy`, `done` and every mask bit are 0, and every element of every register reads 0.
- R2: `start` is accepted on a rising edge where `busy` is low. `busy` is then high for the whole run. `done` is high for exactly one cycle, in the first cycle after the run, with `busy` low. A `start` seen while `busy` is high is ignored.
- R3: Elements are signed two's-complement, `EW` bits wide. The `op` codes are: 0 add and 1 multiply, both keeping the low `EW` bits. Code 2 is an arithmetic shift right of source A by the low log2(`EW`) bits of the B element. Code 3 copies A.
- R4: For codes 0 to 3, destination element i is written only when mask bit i is 1 and i is below the vector length. All other destination elements keep their values.
- R5: Compare codes write mask bit i for every i below the vector length, whatever the mask held before: 4 sets the bit when A >= B (signed), 5 when A equals zero, 6 when A is non-zero. Mask bits at or above the vector length become 0. No register changes.
- R6: A `mask_flip` pulse seen while the unit is idle and `start` is low inverts all `NELEM` mask bits on that edge. It is ignored while `busy` is high.
- R7: With `dense_mode` low, and for every compare, `busy` stays high for max(L,1) cycles, where L is the effective vector length.
- R8: With `dense_mode` high, an arithmetic or copy run keeps `busy` high for max(P,1) cycles. P is the number of set mask bits below L.
- R9: The registers and mask at the end of a run are the same in both modes.
- R10: A `vlen` above `NELEM` acts as `NELEM`. Host element loads are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Host element write strobe |
| ld_reg | input | log2(NREG) | Host write register |
| ld_idx | input | log2(NELEM) | Host write element index |
| ld_data | input | EW | Host write value |
| rd_reg | input | log2(NREG) | Read-port register |
| rd_idx | input | log2(NELEM) | Read-port element index |
| rd_data | output | EW | Element value at the read address |
| start | input | 1 | Begin a run (taken when not busy) |
| op | input | 3 | Operation code |
| dense_mode | input | 1 | 1 selects density-time sequencing |
| vlen | input | log2(NELEM+1) | Vector length |
| src_a | input | log2(NREG) | Source A register |
| src_b | input | log2(NREG) | Source B register |
| dst | input | log2(NREG) | Destination register |
| mask_flip | input | 1 | Complement the mask |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| mask_out | output | NELEM | Current mask register |

## Verification
The operations are swept over every vector length from 0 to one past the register size, in both modes. The mask for each sweep comes from a zero-test compare, and its pattern shifts with the length, so runs with dense, sparse and empty masks are compared. Matching busy cycle counts tell gated from skipping sequencing. Matching results in both modes show that skipping loses no element. Length 0 and the oversized length probe the minimum-one-cycle rule and the clamp. A signed compare on mixed-sign data, then a complement and two masked copies, check the mask bit order and the select idiom. One run is disturbed by a load, a complement and a second start while it is busy, to show that all three are ignored.

// File: rtl/vmx_pkg.sv
package vmx_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_MUL  = 3'd1,
    OP_SRA  = 3'd2,
    OP_MOV  = 3'd3,
    OP_CGE  = 3'd4,
    OP_CEQZ = 3'd5,
    OP_CNEZ = 3'd6
  } vop_e;

  function automatic logic op_is_cmp(input logic [2:0] code);
    return (code == OP_CGE) || (code == OP_CEQZ) || (code == OP_CNEZ);
  endfunction
endpackage

// File: rtl/vmx_vrf.sv
module vmx_vrf #(
  parameter int NREG  = 4,
  parameter int NELEM = 8,
  parameter int EW    = 8,
  localparam int RW = $clog2(NREG),
  localparam int IW = $clog2(NELEM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] w_reg,
  input  logic [IW-1:0] w_idx,
  input  logic [EW-1:0] w_data,
  input  logic [RW-1:0] a_reg,
  input  logic [IW-1:0] a_idx,
  output logic [EW-1:0] a_data,
  input  logic [RW-1:0] b_reg,
  input  logic [IW-1:0] b_idx,
  output logic [EW-1:0] b_data,
  input  logic [RW-1:0] h_reg,
  input  logic [IW-1:0] h_idx,
  output logic [EW-1:0] h_data
);
  logic [NELEM-1:0][EW-1:0] bank [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank[r] <= '0;
      end else if (we && (w_reg == RW'(r))) begin
        bank[r][w_idx] <= w_data;
      end
    end
  end

  assign a_data = bank[a_reg][a_idx];
  assign b_data = bank[b_reg][b_idx];
  assign h_data = bank[h_reg][h_idx];
endmodule

// File: rtl/vmx_alu.sv
module vmx_alu
  import vmx_pkg::*;
#(
  parameter int EW = 8,
  localparam int SHW = (EW > 1) ? $clog2(EW) : 1
) (
  input  logic [2:0]    op,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  output logic [EW-1:0] res,
  output logic          flag
);
  logic [2*EW-1:0] prod;
  logic [SHW-1:0]  amt;

  assign prod = {{EW{1'b0}}, a} * {{EW{1'b0}}, b};
  assign amt  = b[SHW-1:0];

  always_comb begin
    res  = a;
    flag = 1'b0;
    unique case (op)
      OP_ADD:  res = a + b;
      OP_MUL:  res = prod[EW-1:0];
      OP_SRA:  res = $signed(a) >>> amt;
      OP_CGE:  flag = ($signed(a) >= $signed(b));
      OP_CEQZ: flag = (a == '0);
      OP_CNEZ: flag = (a != '0);
      default: res = a;
    endcase
  end
endmodule

// File: rtl/vmx_seq.sv
module vmx_seq #(
  parameter int NELEM = 8,
  localparam int IW = $clog2(NELEM),
  localparam int LW = $clog2(NELEM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             dense,
  input  logic             every,
  input  logic [LW-1:0]    vlen,
  input  logic [NELEM-1:0] mask,
  output logic             busy,
  output logic             done,
  output logic             fire,
  output logic [IW-1:0]    idx
);
  logic [NELEM-1:0] pend, lenm, pick, rest;

  for (genvar i = 0; i < NELEM; i++) begin : g_len
    assign lenm[i] = (vlen > LW'(i));
  end

  // lowest pending element is served first
  always_comb begin
    idx = '0;
    for (int i = NELEM - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end

  assign pick = pend & (~pend + NELEM'(1));
  assign rest = pend & ~pick;
  assign fire = busy & (|pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (go) begin
      pend <= (every || !dense) ? lenm : (lenm & mask);
      busy <= 1'b1;
      done <= 1'b0;
    end else if (busy) begin
      pend <= rest;
      if (rest == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/vmx_unit.sv
module vmx_unit
  import vmx_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int NELEM = 8,
  parameter int EW    = 8,
  localparam int RW = $clog2(NREG),
  localparam int IW = $clog2(NELEM),
  localparam int LW = $clog2(NELEM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [RW-1:0]    ld_reg,
  input  logic [IW-1:0]    ld_idx,
  input  logic [EW-1:0]    ld_data,
  input  logic [RW-1:0]    rd_reg,
  input  logic [IW-1:0]    rd_idx,
  output logic [EW-1:0]    rd_data,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic             dense_mode,
  input  logic [LW-1:0]    vlen,
  input  logic [RW-1:0]    src_a,
  input  logic [RW-1:0]    src_b,
  input  logic [RW-1:0]    dst,
  input  logic             mask_flip,
  output logic             busy,
  output logic             done,
  output logic [NELEM-1:0] mask_out
);
  logic             go, fire, run_cmp, new_cmp, flag, exec_we, we;
  logic [IW-1:0]    idx, w_idx;
  logic [LW-1:0]    vlen_c, run_vlen;
  logic [2:0]       run_op;
  logic [RW-1:0]    run_a, run_b, run_dst, w_reg;
  logic [NELEM-1:0] mask_q, run_mask;
  logic [EW-1:0]    ea, eb, eres, w_data;

  assign go      = start & ~busy;
  assign new_cmp = op_is_cmp(op);
  assign vlen_c  = (vlen > LW'(NELEM)) ? LW'(NELEM) : vlen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_op   <= OP_ADD;
      run_cmp  <= 1'b0;
      run_a    <= '0;
      run_b    <= '0;
      run_dst  <= '0;
      run_vlen <= '0;
      run_mask <= '0;
    end else if (go) begin
      run_op   <= op;
      run_cmp  <= new_cmp;
      run_a    <= src_a;
      run_b    <= src_b;
      run_dst  <= dst;
      run_vlen <= vlen_c;
      run_mask <= mask_q;
    end
  end

  vmx_seq #(.NELEM(NELEM)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .dense(dense_mode), .every(new_cmp),
    .vlen(vlen_c), .mask(mask_q), .busy(busy), .done(done), .fire(fire), .idx(idx)
  );

  vmx_alu #(.EW(EW)) u_alu (
    .op(run_op), .a(ea), .b(eb), .res(eres), .flag(flag)
  );

  assign exec_we = fire & ~run_cmp & run_mask[idx];
  assign we      = exec_we | (ld_en & ~busy);
  assign w_reg   = exec_we ? run_dst : ld_reg;
  assign w_idx   = exec_we ? idx : ld_idx;
  assign w_data  = exec_we ? eres : ld_data;

  vmx_vrf #(.NREG(NREG), .NELEM(NELEM), .EW(EW)) u_vrf (
    .clk(clk), .rst_n(rst_n), .we(we), .w_reg(w_reg), .w_idx(w_idx), .w_data(w_data),
    .a_reg(run_a), .a_idx(idx), .a_data(ea),
    .b_reg(run_b), .b_idx(idx), .b_data(eb),
    .h_reg(rd_reg), .h_idx(rd_idx), .h_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (go && new_cmp) begin
      mask_q <= '0;
    end else if (fire && run_cmp) begin
      mask_q[idx] <= flag;
    end else if (mask_flip && !busy && !start) begin
      mask_q <= ~mask_q;
    end
  end

  assign mask_out = mask_q;
endmodule

// File: rtl/vmx_unit_chk.sv
module vmx_unit_chk #(
  parameter int NELEM = 8,
  parameter int LW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             run_cmp,
  input logic [LW-1:0]    run_vlen,
  input logic [NELEM-1:0] mask_out
);
  logic [NELEM-1:0] lenm;
  logic [LW:0]      cnt, limit;

  always_comb begin
    for (int i = 0; i < NELEM; i++) lenm[i] = (run_vlen > LW'(i));
  end
  assign limit = (run_vlen == '0) ? (LW+1)'(1) : {1'b0, run_vlen};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (busy) cnt <= cnt + 1'b1;
    else cnt <= '0;
  end

  AST_GO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !run_cmp) |-> $stable(mask_out)); // R6
  AST_CMP_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && run_cmp) |-> ((mask_out & ~lenm) == '0)); // R5
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < limit)); // R7
endmodule

bind vmx_unit vmx_unit_chk #(.NELEM(NELEM), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .run_cmp(run_cmp), .run_vlen(run_vlen), .mask_out(mask_out)
);

// File: tb/vmx_unit_tb.sv
module vmx_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4, NE = 8, W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_en = 0, start = 0, dense_mode = 0, mask_flip = 0;
  logic [1:0] ld_reg = 0, rd_reg = 0, src_a = 0, src_b = 0, dst = 0;
  logic [2:0] ld_idx = 0, rd_idx = 0, op = 0;
  logic [7:0] ld_data = 0;
  logic [3:0] vlen = 0;
  logic [7:0] rd_data;
  logic busy, done;
  logic [7:0] mask_out;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [7:0] vm [NR][NE];
  logic [7:0] mm;

  always #(CLK_PERIOD/2) clk = ~clk;

  vmx_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_reg(ld_reg), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data), .start(start), .op(op),
    .dense_mode(dense_mode), .vlen(vlen), .src_a(src_a), .src_b(src_b), .dst(dst),
    .mask_flip(mask_flip), .busy(busy), .done(done), .mask_out(mask_out)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic load(input int r, input int i, input logic [7:0] v);
    @(negedge clk);
    ld_en = 1; ld_reg = 2'(r); ld_idx = 3'(i); ld_data = v;
    vm[r][i] = v;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic check_reg(input int r, input string req);
    logic [63:0] act, exp;
    act = '0; exp = '0;
    for (int i = 0; i < NE; i++) begin
      rd_reg = 2'(r); rd_idx = 3'(i); #1;
      act[i*8 +: 8] = rd_data;
      exp[i*8 +: 8] = vm[r][i];
    end
    chk(act == exp, req, act, exp);
  endtask

  function automatic logic [7:0] elem_res(input int code, input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = 16'(a) * 16'(b);
    case (code)
      0: return a + b;
      1: return p[7:0];
      2: return 8'($signed(a) >>> b[2:0]);
      default: return a;
    endcase
  endfunction

  // R2 R7 R8: run one operation, measure busy, update the model
  task automatic run(input int code, input int a, input int b, input int d, input int vl,
                     input bit dn, input bit disturb);
    int L, pc, expc, cnt;
    bit cmp;
    logic [7:0] keep_mask;
    L = (vl > NE) ? NE : vl;
    cmp = (code >= 4);
    pc = 0;
    for (int i = 0; i < L; i++) if (mm[i]) pc++;
    expc = (cmp || !dn) ? ((L == 0) ? 1 : L) : ((pc == 0) ? 1 : pc);
    keep_mask = mm;
    if (cmp) begin
      mm = '0;
      for (int i = 0; i < L; i++) begin
        case (code)
          4: mm[i] = ($signed(vm[a][i]) >= $signed(vm[b][i]));
          5: mm[i] = (vm[a][i] == 0);
          default: mm[i] = (vm[a][i] != 0);
        endcase
      end
    end else begin
      for (int i = 0; i < L; i++) if (keep_mask[i]) vm[d][i] = elem_res(code, vm[a][i], vm[b][i]);
    end
    @(negedge clk);
    op = 3'(code); src_a = 2'(a); src_b = 2'(b); dst = 2'(d); vlen = 4'(vl); dense_mode = dn; start = 1;
    @(negedge clk);
    start = 0; cnt = 0;
    while (busy) begin
      cnt++;
      if (disturb && cnt == 1) begin
        ld_en = 1; ld_reg = 2'(a); ld_idx = 0; ld_data = ~vm[a][0];
        mask_flip = 1; start = 1; op = 3'd4; dst = 2'(a);
      end else begin
        ld_en = 0; mask_flip = 0; start = 0;
      end
      @(negedge clk);
    end
    ld_en = 0; mask_flip = 0; start = 0;
    chk(done == 1'b1, "R2 done pulse after run", 64'(done), 64'd1);
    chk(cnt == expc, dn ? "R8 dense busy cycles" : "R7 gated busy cycles", 64'(cnt), 64'(expc));
    chk(mask_out == mm, cmp ? "R5 mask from compare" : "R9 mask kept", 64'(mask_out), 64'(mm));
    if (!cmp) check_reg(d, dn ? "R9 R4 R3 dense result" : "R4 R3 gated result");
    @(negedge clk);
    chk(done == 1'b0, "R2 done one cycle", 64'(done), 64'd0);
  endtask

  task automatic flip();
    @(negedge clk);
    mask_flip = 1; mm = ~mm;
    @(negedge clk);
    mask_flip = 0;
  endtask

  initial begin
    logic [7:0] va [NE] = '{8'd1, 8'd2, 8'd3, 8'd4, -8'sd5, 8'd0, 8'd6, -8'sd7};
    logic [7:0] vb [NE] = '{8'd2, 8'd2, 8'd2, 8'd10, -8'sd4, -8'sd3, 8'd5, -8'sd8};
    logic [7:0] vmax [NE] = '{8'd2, 8'd2, 8'd3, 8'd10, -8'sd4, 8'd0, 8'd6, -8'sd7};
    for (int r = 0; r < NR; r++) for (int i = 0; i < NE; i++) vm[r][i] = '0;
    mm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy at reset", 64'(busy), 0);
    chk(done == 0, "R1 done at reset", 64'(done), 0);
    chk(mask_out == 0, "R1 mask at reset", 64'(mask_out), 0);
    for (int r = 0; r < NR; r++) check_reg(r, "R1 register zero at reset");

    // R5 signed compare, bit i = element i
    for (int i = 0; i < NE; i++) begin load(0, i, va[i]); load(1, i, vb[i]); end
    run(4, 0, 1, 2, 8, 0, 0);
    chk(mask_out == 8'b1110_0110, "R5 signed ge mask", 64'(mask_out), 64'hE6);
    // R6 complement
    flip();
    chk(mask_out == 8'b0001_1001, "R6 mask complement", 64'(mask_out), 64'h19);
    flip();
    // R4 select via two masked copies
    for (int i = 0; i < NE; i++) load(2, i, 8'hAA);
    run(3, 0, 0, 2, 8, 1, 0);
    flip();
    run(3, 1, 1, 2, 8, 0, 0);
    for (int i = 0; i < NE; i++) vm[3][i] = vmax[i];
    begin
      logic [63:0] act, exp;
      for (int i = 0; i < NE; i++) begin
        rd_reg = 2; rd_idx = 3'(i); #1;
        act[i*8 +: 8] = rd_data; exp[i*8 +: 8] = vmax[i];
      end
      chk(act == exp, "R4 select gives element max", act, exp);
    end

    // sweep: lengths 0..9 (9 probes R10 clamp), both modes, all arithmetic codes
    for (int vl = 0; vl <= 9; vl++) begin
      for (int dn = 0; dn < 2; dn++) begin
        for (int i = 0; i < NE; i++) begin
          load(0, i, 8'(i*37 + vl*11 + 5));
          load(1, i, 8'(i*53 + vl*7 + 200));
          load(3, i, (((i + vl + dn) % 3) == 0) ? 8'd0 : 8'(i + 1));
        end
        run(6, 3, 3, 2, vl, dn[0], 0);
        for (int c = 0; c < 4; c++) begin
          for (int i = 0; i < NE; i++) load(2, i, 8'(8'h5A ^ i));
          run(c, 0, 1, 2, vl, dn[0], 0);
        end
        run(5, 3, 3, 2, vl, dn[0], 0);
      end
    end

    // R10 R2 R6: load, complement and second start while busy are ignored
    run(6, 3, 3, 2, 8, 0, 0);
    run(0, 0, 1, 2, 8, 0, 1);
    check_reg(0, "R10 load ignored while busy");
    chk(mask_out == mm, "R6 flip ignored while busy", 64'(mask_out), 64'(mm));

    finish_run();
  end
endmodule